// File: doc/BRIEF.md
# Banked Auxiliary Control Register

This block is a small register bank behind a simple parallel bus (3-bit address, 8-bit write and read data, write and read strobes). It holds three normal 8-bit control registers and one auxiliary register. The auxiliary register has no address of its own: it shares the address of the third control register. A bank-select bit in the second control register decides which of the two that address reaches.

The auxiliary register mixes stored and live bits. Its lower nibble holds writable controls: a transmit source select and a two-bit signal quality threshold code. Its upper nibble is read-only. On a read it returns the present level of the transmit baud clock and the received bit taken before descrambling, next to fixed zeros.

The block also drives the transmit data bit. It chooses between the input pin and an alternate data bit held in the third control register. A two-bit test pattern code in the first control register can override both sources with alternating, all-mark or all-space data.

Top module: `banked_aux_ctl`

## Requirements
- R1: After reset, every stored bit is zero: reads of addresses 1, 2 and 3 return 0x00, rdData is 0x00, and txOut follows txdPin.
- R2: Address 1 reaches control register 1, address 2 reaches control register 2, and address 3 reaches control register 3 while the bank bit is 0. Other addresses read 0x00 and ignore writes. rdData is loaded at the clock edge where rdStb is high and holds its value when rdStb is low.
- R3: While the bank bit (bit 6 of control register 2) is 1, reads and writes of address 3 reach the auxiliary register and not control register 3.
- R4: A write to the auxiliary register leaves control register 3 unchanged, and a write to control register 3 leaves the auxiliary register unchanged.
- R5: Auxiliary bits 7, 4 and 0 always read as 0, whatever was written to them.
- R6: Auxiliary bit 6 reads the level of txBaudClk and bit 5 reads rxRawBit, both as sampled at the read edge. Writes to bits 6 and 5 have no effect.
- R7: Auxiliary bits 3, 2 and 1 are stored on write and read back unchanged.
- R8: With pattern code 00 (control register 1 bits 7:6), txOut equals txdPin when auxiliary bit 3 is 0, and equals bit 7 of control register 3 when auxiliary bit 3 is 1.
- R9: Pattern code 10 forces txOut to 1 (mark) and code 11 forces txOut to 0 (space), whatever the selected source.
- R10: Pattern code 01 makes txOut alternate: it is 1 when the code is entered, and inverts after each clock edge at which txBaudClk is seen rising (high now, low at the previous edge).
- R11: The thrCode output equals auxiliary bits 2:1 (bit 2 is the high bit of the code).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| wrStb | input | 1 | Write strobe |
| rdStb | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| txBaudClk | input | 1 | Transmit baud clock level |
| rxRawBit | input | 1 | Received bit before descrambling |
| txdPin | input | 1 | Transmit data from the pin |
| txOut | output | 1 | Selected transmit data bit |
| thrCode | output | 2 | Signal quality threshold code |

## Verification
On every cycle the assertions check that at most one register is written, that the shared address only reaches the auxiliary register under the bank bit and only reaches control register 3 without it, that a write to one of the two leaves the other untouched, that read data holds between reads, that the reserved auxiliary bits read zero, and that the alternating pattern only changes after a baud clock rise. Only the bench scenarios show the actual stored values, the live status bits sampled at the read edge, the source multiplexer choices for each pattern code, and that unmapped addresses ignore writes.

// File: rtl/banked_aux_pkg.sv
package banked_aux_pkg;

  localparam int DATA_W = 8;

  // bit positions that other logic decodes
  localparam int BANK_BIT     = 6;  // control register 2
  localparam int PAT_HI       = 7;  // control register 1
  localparam int PAT_LO       = 6;
  localparam int ALT_TX_BIT   = 7;  // control register 3
  localparam int AUX_SRC_BIT  = 2;  // index into the stored aux bits
  localparam int AUX_STORED_W = 3;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CR1  = 3'd1,
    SEL_CR2  = 3'd2,
    SEL_CR3  = 3'd3,
    SEL_AUX  = 3'd4
  } rdSel_e;

  typedef enum logic [1:0] {
    PAT_OFF   = 2'b00,
    PAT_ALT   = 2'b01,
    PAT_MARK  = 2'b10,
    PAT_SPACE = 2'b11
  } pattern_e;

  typedef struct packed {
    logic   wrCr1;
    logic   wrCr2;
    logic   wrCr3;
    logic   wrAux;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/banked_aux_decode.sv
module banked_aux_decode
  import banked_aux_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CR1_ADDR = 1,
  parameter int CR2_ADDR = 2,
  parameter int CR3_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic              bankSel,
  output regStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(CR1_ADDR);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(CR2_ADDR);
  localparam logic [ADDR_W-1:0] A3 = ADDR_W'(CR3_ADDR);

  rdSel_e target;

  always_comb begin
    if (addr == A1)      target = SEL_CR1;
    else if (addr == A2) target = SEL_CR2;
    else if (addr == A3) target = bankSel ? SEL_AUX : SEL_CR3;
    else                 target = SEL_NONE;
  end

  always_comb begin
    strb.wrCr1 = wrStb && (target == SEL_CR1);
    strb.wrCr2 = wrStb && (target == SEL_CR2);
    strb.wrCr3 = wrStb && (target == SEL_CR3);
    strb.wrAux = wrStb && (target == SEL_AUX);
    strb.rdEn  = rdStb;
    strb.rdSel = target;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrCr1, strb.wrCr2, strb.wrCr3, strb.wrAux})) else $error("one write"); // R2

  AST_AUX_NEEDS_BANK: assert property (@(posedge clk) disable iff (rst)
    strb.wrAux |-> (bankSel && wrStb)) else $error("aux without bank"); // R3

  AST_CR3_NEEDS_NO_BANK: assert property (@(posedge clk) disable iff (rst)
    strb.wrCr3 |-> !bankSel) else $error("cr3 under bank"); // R3

endmodule

// File: rtl/banked_aux_datapath.sv
module banked_aux_datapath
  import banked_aux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txBaudClk,
  input  logic              rxRawBit,
  input  logic              txdPin,
  output logic              bankSel,
  output logic [DATA_W-1:0] rdData,
  output logic              txOut,
  output logic [1:0]        thrCode
);

  logic [DATA_W-1:0]       cr1Reg, cr2Reg, cr3Reg;
  logic [AUX_STORED_W-1:0] auxBits;   // {source, threshold[1:0]}
  logic [DATA_W-1:0]       rdNext;
  logic                    baudPrev, baudRise, altPhase;
  pattern_e                patCode;

  // stored registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cr1Reg  <= '0;
      cr2Reg  <= '0;
      cr3Reg  <= '0;
      auxBits <= '0;
    end else begin
      if (strb.wrCr1) cr1Reg  <= wrData;
      if (strb.wrCr2) cr2Reg  <= wrData;
      if (strb.wrCr3) cr3Reg  <= wrData;
      if (strb.wrAux) auxBits <= wrData[3:1];
    end
  end

  assign bankSel = cr2Reg[BANK_BIT];
  assign thrCode = auxBits[1:0];

  // read path: live status next to stored bits
  always_comb begin
    unique case (strb.rdSel)
      SEL_CR1: rdNext = cr1Reg;
      SEL_CR2: rdNext = cr2Reg;
      SEL_CR3: rdNext = cr3Reg;
      SEL_AUX: rdNext = {1'b0, txBaudClk, rxRawBit, 1'b0, auxBits, 1'b0};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  // transmit data selection
  assign patCode  = pattern_e'(cr1Reg[PAT_HI:PAT_LO]);
  assign baudRise = txBaudClk && !baudPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      baudPrev <= 1'b0;
      altPhase <= 1'b1;
    end else begin
      baudPrev <= txBaudClk;
      if (patCode != PAT_ALT) altPhase <= 1'b1;
      else if (baudRise)      altPhase <= !altPhase;
    end
  end

  always_comb begin
    unique case (patCode)
      PAT_ALT:   txOut = altPhase;
      PAT_MARK:  txOut = 1'b1;
      PAT_SPACE: txOut = 1'b0;
      default:   txOut = auxBits[AUX_SRC_BIT] ? cr3Reg[ALT_TX_BIT] : txdPin;
    endcase
  end

  AST_AUX_WR_KEEPS_CR3: assert property (@(posedge clk) disable iff (rst)
    strb.wrAux |=> $stable(cr3Reg)) else $error("cr3 disturbed"); // R4

  AST_CR3_WR_KEEPS_AUX: assert property (@(posedge clk) disable iff (rst)
    strb.wrCr3 |=> $stable(auxBits)) else $error("aux disturbed"); // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |=> $stable(rdData)) else $error("read data moved"); // R2

  AST_AUX_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.rdSel == SEL_AUX) |=> (!rdData[7] && !rdData[4] && !rdData[0]))
    else $error("reserved bit set"); // R5

  AST_ALT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (patCode == PAT_ALT && $past(patCode) == PAT_ALT && !$past(baudRise)) |-> $stable(txOut))
    else $error("alternate moved without baud rise"); // R10

endmodule

// File: rtl/banked_aux_ctl.sv
module banked_aux_ctl
  import banked_aux_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CR1_ADDR = 1,
  parameter int CR2_ADDR = 2,
  parameter int CR3_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrStb,
  input  logic              rdStb,
  output logic [7:0]        rdData,
  input  logic              txBaudClk,
  input  logic              rxRawBit,
  input  logic              txdPin,
  output logic              txOut,
  output logic [1:0]        thrCode
);

  regStrobe_t strb;
  logic       bankSel;

  banked_aux_decode #(
    .ADDR_W(ADDR_W), .CR1_ADDR(CR1_ADDR), .CR2_ADDR(CR2_ADDR), .CR3_ADDR(CR3_ADDR)
  ) u_decode (
    .clk(clk), .rst(rst), .addr(addr), .wrStb(wrStb), .rdStb(rdStb),
    .bankSel(bankSel), .strb(strb)
  );

  banked_aux_datapath u_data (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .txBaudClk(txBaudClk), .rxRawBit(rxRawBit), .txdPin(txdPin),
    .bankSel(bankSel), .rdData(rdData), .txOut(txOut), .thrCode(thrCode)
  );

endmodule

// File: tb/banked_aux_ctl_test.sv
module banked_aux_ctl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrStb = 1'b0, rdStb = 1'b0;
  logic [7:0] rdData;
  logic       txBaudClk = 1'b0, rxRawBit = 1'b0, txdPin = 1'b0;
  logic       txOut;
  logic [1:0] thrCode;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10ns clk = ~clk;  // 50 MHz

  banked_aux_ctl uut (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrStb(wrStb), .rdStb(rdStb),
    .rdData(rdData), .txBaudClk(txBaudClk), .rxRawBit(rxRawBit), .txdPin(txdPin),
    .txOut(txOut), .thrCode(thrCode)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk); wrStb = 1'b0;
  endtask

  // driver: pushes the expected value, then issues the read
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); addr = a; rdStb = 1'b1;
    @(negedge clk); rdStb = 1'b0;
  endtask

  task automatic pins(input logic baud, input logic rx, input logic pin);
    @(negedge clk); txBaudClk = baud; rxRawBit = rx; txdPin = pin;
    @(negedge clk);
  endtask

  task automatic checkTx(input logic exp, input string tag);
    #1;
    check8(tag, {7'd0, txOut}, {7'd0, exp});
  endtask

  // monitor: pops and compares when a read has been captured
  initial begin
    forever begin
      @(posedge clk);
      if (rdStb && !rst) begin
        @(negedge clk);
        if (expQ.size() == 0) check8("monitor queue empty", 8'hxx, 8'h00);
        else check8(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check8("R1 rdData after reset", rdData, 8'h00);
    check8("R1 thrCode after reset", {6'd0, thrCode}, 8'h00);
    pins(1'b0, 1'b0, 1'b1); checkTx(1'b1, "R1 txOut follows pin high");
    pins(1'b0, 1'b0, 1'b0); checkTx(1'b0, "R1 txOut follows pin low");
    rd(3'd1, 8'h00, "R1 cr1 reset");
    rd(3'd2, 8'h00, "R1 cr2 reset");
    rd(3'd3, 8'h00, "R1 cr3 reset");

    // R2 address map
    wr(3'd3, 8'hA5); rd(3'd3, 8'hA5, "R2 cr3 readback");
    wr(3'd1, 8'h12); rd(3'd1, 8'h12, "R2 cr1 readback");
    wr(3'd5, 8'hFF); rd(3'd5, 8'h00, "R2 unmapped reads zero");
    rd(3'd1, 8'h12, "R2 unmapped write ignored");
    repeat (2) @(negedge clk);
    check8("R2 rdData holds between reads", rdData, 8'h12);

    // R3 bank select, R5/R7 stored bits
    wr(3'd2, 8'h40);
    wr(3'd3, 8'hFF);
    rd(3'd3, 8'h0E, "R3 R5 R7 aux readback");
    check8("R11 thrCode 11", {6'd0, thrCode}, 8'h03);
    checkTx(1'b1, "R8 alt source cr3 bit7 = 1");
    rd(3'd2, 8'h40, "R3 cr2 still reachable");

    // R6 live status bits
    pins(1'b1, 1'b0, 1'b0); rd(3'd3, 8'h4E, "R6 baud level");
    pins(1'b0, 1'b1, 1'b0); rd(3'd3, 8'h2E, "R6 raw rx bit");
    pins(1'b0, 1'b0, 1'b0);

    wr(3'd3, 8'h04);
    check8("R11 thrCode 10", {6'd0, thrCode}, 8'h02);
    checkTx(1'b0, "R8 pin source low");
    pins(1'b0, 1'b0, 1'b1); checkTx(1'b1, "R8 pin source high");

    // R4 isolation
    wr(3'd2, 8'h00);
    rd(3'd3, 8'hA5, "R4 cr3 unchanged by aux writes");
    wr(3'd3, 8'h5A);
    wr(3'd2, 8'h40);
    rd(3'd3, 8'h04, "R4 aux unchanged by cr3 write");

    // R8 alternate source with cr3 bit7 = 0
    wr(3'd3, 8'h08);
    checkTx(1'b0, "R8 alt source cr3 bit7 = 0 with pin high");

    // R9 forced patterns
    wr(3'd1, 8'h80); checkTx(1'b1, "R9 mark");
    pins(1'b0, 1'b0, 1'b0); checkTx(1'b1, "R9 mark ignores pin");
    wr(3'd1, 8'hC0); checkTx(1'b0, "R9 space");

    // R10 alternating pattern
    wr(3'd1, 8'h40); checkTx(1'b1, "R10 starts at one");
    @(negedge clk); checkTx(1'b1, "R10 steady without rise");
    @(negedge clk); txBaudClk = 1'b1;
    @(negedge clk); checkTx(1'b0, "R10 inverted after rise");
    repeat (3) @(negedge clk); checkTx(1'b0, "R10 steady while baud high");
    txBaudClk = 1'b0;
    @(negedge clk); checkTx(1'b0, "R10 no change on fall");
    txBaudClk = 1'b1;
    @(negedge clk); checkTx(1'b1, "R10 inverted after second rise");

    wr(3'd1, 8'h00); checkTx(1'b0, "R8 source restored after pattern off");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule